// File: doc/BRIEF.md
# MD5 Block Compression Core

This core compresses one 512-bit message block under the MD5 hash. It takes a 128-bit chaining seed and sixteen 32-bit message words. It runs the 64 hash steps at one step per clock. At the end it adds each working word to the matching seed word, and the four sums are the next chaining value. A host that hashes a whole message does the padding and length field itself. It feeds blocks one at a time and passes each result back in as the next seed.

The step datapath splits the work to shorten the path through each step. The sum of the outgoing working word, the scheduled message word and the sine-derived constant for a step is formed one cycle ahead, in its own register. Only four operations wait on the word the previous step produced: the round's logic function, one add, the rotate and the final add.

Top module: `md5_core`

## Requirements
- R1: While reset is held and after it is released, busy and done are low and digest reads zero until the first block completes.
- R2: With the standard initial seed (words 0x67452301, 0xefcdab89, 0x98badcfe, 0x10325476 in bits 31:0 upward), the digest of a correctly padded block matches the published MD5 value. Message word k sits in block bits 32k+31:32k and digest word A in bits 31:0. Bytes are little-endian within each word.
- R3: For an arbitrary seed, digest equals the seed plus the 64-step compression result, word by word modulo 2^32.
- R4: busy is high on the cycle after a start is accepted. done is high exactly 65 clock edges after the edge that accepted start.
- R5: done is a single-cycle pulse.
- R6: start is ignored while busy. Changing start, seed or block during a run does not alter that run's digest.
- R7: digest holds its value between completions.
- R8: busy is low whenever done is high, so a new start may be given on the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin compressing; sampled only while idle |
| seed | input | 128 | Chaining seed, word A in bits 31:0 |
| block | input | 512 | Sixteen message words, word 0 in bits 31:0 |
| busy | output | 1 | Compression in progress |
| done | output | 1 | One-cycle pulse when digest is updated |
| digest | output | 128 | Next chaining value, word A in bits 31:0 |

## Verification
The hardest case to reach from the ports is a start request, with a different block and seed, arriving while a run is in progress. It would corrupt the result only if the inputs were sampled again after the load cycle. The bench holds start high for several mid-run cycles with the inputs changed. It then requires the run's original digest. Chained seeds that are not the standard initial value are covered by a straightforward reference computation in the bench. That computation derives its constants from the sine function.

// File: rtl/md5_pkg.sv
package md5_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 16;
  localparam int NUM_STEPS = 64;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int IDX_W     = $clog2(NUM_WORDS);

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } strobe_t;

  function automatic word_t stepConst(input logic [STEP_W-1:0] i);
    case (i)
      6'd0:  return 32'hd76aa478; 6'd1:  return 32'he8c7b756;
      6'd2:  return 32'h242070db; 6'd3:  return 32'hc1bdceee;
      6'd4:  return 32'hf57c0faf; 6'd5:  return 32'h4787c62a;
      6'd6:  return 32'ha8304613; 6'd7:  return 32'hfd469501;
      6'd8:  return 32'h698098d8; 6'd9:  return 32'h8b44f7af;
      6'd10: return 32'hffff5bb1; 6'd11: return 32'h895cd7be;
      6'd12: return 32'h6b901122; 6'd13: return 32'hfd987193;
      6'd14: return 32'ha679438e; 6'd15: return 32'h49b40821;
      6'd16: return 32'hf61e2562; 6'd17: return 32'hc040b340;
      6'd18: return 32'h265e5a51; 6'd19: return 32'he9b6c7aa;
      6'd20: return 32'hd62f105d; 6'd21: return 32'h02441453;
      6'd22: return 32'hd8a1e681; 6'd23: return 32'he7d3fbc8;
      6'd24: return 32'h21e1cde6; 6'd25: return 32'hc33707d6;
      6'd26: return 32'hf4d50d87; 6'd27: return 32'h455a14ed;
      6'd28: return 32'ha9e3e905; 6'd29: return 32'hfcefa3f8;
      6'd30: return 32'h676f02d9; 6'd31: return 32'h8d2a4c8a;
      6'd32: return 32'hfffa3942; 6'd33: return 32'h8771f681;
      6'd34: return 32'h6d9d6122; 6'd35: return 32'hfde5380c;
      6'd36: return 32'ha4beea44; 6'd37: return 32'h4bdecfa9;
      6'd38: return 32'hf6bb4b60; 6'd39: return 32'hbebfbc70;
      6'd40: return 32'h289b7ec6; 6'd41: return 32'heaa127fa;
      6'd42: return 32'hd4ef3085; 6'd43: return 32'h04881d05;
      6'd44: return 32'hd9d4d039; 6'd45: return 32'he6db99e5;
      6'd46: return 32'h1fa27cf8; 6'd47: return 32'hc4ac5665;
      6'd48: return 32'hf4292244; 6'd49: return 32'h432aff97;
      6'd50: return 32'hab9423a7; 6'd51: return 32'hfc93a039;
      6'd52: return 32'h655b59c3; 6'd53: return 32'h8f0ccc92;
      6'd54: return 32'hffeff47d; 6'd55: return 32'h85845dd1;
      6'd56: return 32'h6fa87e4f; 6'd57: return 32'hfe2ce6e0;
      6'd58: return 32'ha3014314; 6'd59: return 32'h4e0811a1;
      6'd60: return 32'hf7537e82; 6'd61: return 32'hbd3af235;
      6'd62: return 32'h2ad7d2bb; default: return 32'heb86d391;
    endcase
  endfunction

  // Message word scheduled for a step
  function automatic logic [IDX_W-1:0] wordSel(input logic [STEP_W-1:0] i);
    logic [7:0] j;
    logic [7:0] r;
    j = {4'd0, i[3:0]};
    case (i[5:4])
      2'd0:    r = j;
      2'd1:    r = 8'd5 * j + 8'd1;
      2'd2:    r = 8'd3 * j + 8'd5;
      default: r = 8'd7 * j;
    endcase
    return r[IDX_W-1:0];
  endfunction

  function automatic logic [5:0] shiftAmt(input logic [STEP_W-1:0] i);
    logic [1:0] k;
    k = i[1:0];
    case (i[5:4])
      2'd0:    return (k == 2'd0) ? 6'd7 : (k == 2'd1) ? 6'd12 : (k == 2'd2) ? 6'd17 : 6'd22;
      2'd1:    return (k == 2'd0) ? 6'd5 : (k == 2'd1) ? 6'd9  : (k == 2'd2) ? 6'd14 : 6'd20;
      2'd2:    return (k == 2'd0) ? 6'd4 : (k == 2'd1) ? 6'd11 : (k == 2'd2) ? 6'd16 : 6'd23;
      default: return (k == 2'd0) ? 6'd6 : (k == 2'd1) ? 6'd10 : (k == 2'd2) ? 6'd15 : 6'd21;
    endcase
  endfunction

  function automatic word_t roundFn(input logic [1:0] rnd, input word_t x,
                                    input word_t y, input word_t z);
    case (rnd)
      2'd0:    return (x & y) | (~x & z);
      2'd1:    return (x & z) | (y & ~z);
      2'd2:    return x ^ y ^ z;
      default: return y ^ (x | ~z);
    endcase
  endfunction
endpackage

// File: rtl/md5_control.sv
module md5_control
  import md5_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output strobe_t           strobes,
  output logic [STEP_W-1:0] stepIdx,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FINAL} state_t;
  state_t state;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  always_comb begin
    strobes.load   = (state == S_IDLE) && start;
    strobes.step   = (state == S_RUN);
    strobes.finish = (state == S_FINAL);
  end

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      stepIdx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          state   <= S_RUN;
          stepIdx <= '0;
        end
        S_RUN: begin
          stepIdx <= stepIdx + 1'b1;
          if (stepIdx == LAST_STEP) state <= S_FINAL;
        end
        default: begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/md5_datapath.sv
module md5_datapath
  import md5_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       strobes,
  input  logic [STEP_W-1:0]             stepIdx,
  input  logic [4*WORD_W-1:0]           seed,
  input  logic [NUM_WORDS*WORD_W-1:0]   block,
  output logic [4*WORD_W-1:0]           digest
);
  word_t msgW [NUM_WORDS];
  word_t seedW [4];
  word_t wa, wb, wc, wd;
  word_t preSum;
  word_t mixed, rotated, newB, nextPre;
  logic [STEP_W-1:0] nextIdx;
  logic [5:0] sh;

  // Only this chain waits on the word produced last cycle
  always_comb begin
    sh      = shiftAmt(stepIdx);
    mixed   = preSum + roundFn(stepIdx[5:4], wb, wc, wd);
    rotated = (mixed << sh) | (mixed >> (6'd32 - sh));
    newB    = wb + rotated;
    nextIdx = stepIdx + 1'b1;
    nextPre = wd + msgW[wordSel(nextIdx)] + stepConst(nextIdx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_WORDS; k++) msgW[k] <= '0;
      for (int k = 0; k < 4; k++) seedW[k] <= '0;
      {wa, wb, wc, wd} <= '0;
      preSum <= '0;
      digest <= '0;
    end else begin
      if (strobes.load) begin
        for (int k = 0; k < NUM_WORDS; k++) msgW[k] <= block[k*WORD_W +: WORD_W];
        for (int k = 0; k < 4; k++) seedW[k] <= seed[k*WORD_W +: WORD_W];
        wa <= seed[0 +: WORD_W];
        wb <= seed[WORD_W +: WORD_W];
        wc <= seed[2*WORD_W +: WORD_W];
        wd <= seed[3*WORD_W +: WORD_W];
        preSum <= seed[0 +: WORD_W] + block[0 +: WORD_W] + stepConst('0);
      end
      if (strobes.step) begin
        wa <= wd;
        wb <= newB;
        wc <= wb;
        wd <= wc;
        preSum <= nextPre;
      end
      if (strobes.finish)
        digest <= {seedW[3] + wd, seedW[2] + wc, seedW[1] + wb, seedW[0] + wa};
    end
  end
endmodule

// File: rtl/md5_core.sv
module md5_core
  import md5_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [127:0] seed,
  input  logic [511:0] block,
  output logic         busy,
  output logic         done,
  output logic [127:0] digest
);
  strobe_t strobes;
  logic [STEP_W-1:0] stepIdx;

  md5_control u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .strobes(strobes), .stepIdx(stepIdx), .busy(busy), .done(done)
  );

  md5_datapath u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .stepIdx(stepIdx),
    .seed(seed), .block(block), .digest(digest)
  );
endmodule

// File: rtl/md5_checker.sv
module md5_checker (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] digest
);
  logic [6:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst) runCnt <= '0;
    else if (start && !busy) runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
  end

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r8_idle_on_done: assert property (@(posedge clk) disable iff (rst) done |-> !busy);
  a_r6_busy_needs_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  a_r7_digest_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(digest));
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    done |-> runCnt == 7'd65);
  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> (!busy && !done));
endmodule

bind md5_core md5_checker u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .digest(digest)
);

// File: tb/md5_core_test.sv
`timescale 1ns/1ps
module md5_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [127:0] seed = '0;
  logic [511:0] block = '0;
  logic busy, done;
  logic [127:0] digest;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  md5_core uut (.*);

  localparam logic [127:0] IV = {32'h10325476, 32'h98badcfe, 32'hefcdab89, 32'h67452301};
  localparam int NV = 3;
  localparam logic [511:0] VEC_BLK [NV] = '{
    512'h80,
    (512'h8 << 448) | 512'h8061,
    (512'h18 << 448) | 512'h80636261
  };
  localparam logic [127:0] VEC_DIG [NV] = '{
    {32'h7e42f8ec, 32'h980980e9, 32'h04b2008f, 32'hd98c1dd4},
    {32'h61267769, 32'he299c331, 32'ha8b6f1c0, 32'hb975c10c},
    {32'h727fe128, 32'h7d3f96d6, 32'hb04fd23c, 32'h98500190}
  };

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rotl(input logic [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  // Straightforward reference compression, constants from the sine function
  function automatic logic [127:0] refCompress(input logic [127:0] sd, input logic [511:0] blk);
    logic [31:0] a, b, c, d, f, t, tmp;
    int g, s;
    int sTab [16] = '{7,12,17,22, 5,9,14,20, 4,11,16,23, 6,10,15,21};
    a = sd[31:0]; b = sd[63:32]; c = sd[95:64]; d = sd[127:96];
    for (int i = 0; i < 64; i++) begin
      if (i < 16)      begin f = (b & c) | (~b & d); g = i; end
      else if (i < 32) begin f = (d & b) | (~d & c); g = (5*i + 1) % 16; end
      else if (i < 48) begin f = b ^ c ^ d;          g = (3*i + 5) % 16; end
      else             begin f = c ^ (b | ~d);       g = (7*i) % 16; end
      t = 32'(longint'($floor((($sin(real'(i + 1)) < 0.0) ? -$sin(real'(i + 1))
                                : $sin(real'(i + 1))) * 4294967296.0)));
      s = sTab[(i / 16) * 4 + (i % 4)];
      tmp = d; d = c; c = b;
      b = b + rotl(a + f + t + blk[g*32 +: 32], s);
      a = tmp;
    end
    return {sd[127:96] + d, sd[95:64] + c, sd[63:32] + b, sd[31:0] + a};
  endfunction

  // Runs one block; returns digest and edges from accept to done
  task automatic runBlock(input logic [127:0] sd, input logic [511:0] blk,
                          output logic [127:0] res, output int lat);
    @(negedge clk);
    seed = sd; block = blk; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R4 busy after start", 128'(busy), 128'd1);
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = digest;
    check(busy == 1'b0, "R8 busy low on done", 128'(busy), 128'd0);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] res, exp, held;
    int lat;
    repeat (3) @(negedge clk);
    // R1 during and after reset
    check(!busy && !done && digest == '0, "R1 reset state", {busy, done, digest[125:0]}, 128'd0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && digest == '0, "R1 after release", {busy, done, digest[125:0]}, 128'd0);

    // R2 known vectors from table
    for (int v = 0; v < NV; v++) begin
      runBlock(IV, VEC_BLK[v], res, lat);
      check(res == VEC_DIG[v], "R2 known digest", res, VEC_DIG[v]);
      check(lat == 65, "R4 latency", 128'(lat), 128'd65);
      @(negedge clk);
      check(done == 1'b0, "R5 done single pulse", 128'(done), 128'd0);
    end

    // R7 digest holds while idle
    held = digest;
    repeat (10) @(negedge clk);
    check(digest == held, "R7 digest held idle", digest, held);

    // R3 chained seed against reference model
    exp = refCompress(VEC_DIG[0], VEC_BLK[2]);
    runBlock(VEC_DIG[0], VEC_BLK[2], res, lat);
    check(res == exp, "R3 chained seed", res, exp);
    exp = refCompress(128'h0123456789abcdeffedcba9876543210, {16{32'hdeadbeef}});
    runBlock(128'h0123456789abcdeffedcba9876543210, {16{32'hdeadbeef}}, res, lat);
    check(res == exp, "R3 arbitrary seed", res, exp);

    // R6 start and inputs changed mid-run are ignored; R7 digest unchanged mid-run
    held = digest;
    @(negedge clk);
    seed = IV; block = VEC_BLK[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    seed = ~IV; block = VEC_BLK[2]; start = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b0;
    check(digest == held, "R7 digest held mid-run", digest, held);
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(digest == VEC_DIG[0], "R6 start ignored while busy", digest, VEC_DIG[0]);
    @(negedge clk);
    check(busy == 1'b0, "R6 no extra run", 128'(busy), 128'd0);

    // R8 back-to-back: start given on the done cycle
    @(negedge clk);
    seed = IV; block = VEC_BLK[1]; start = 1'b1;
    @(negedge clk);
    block = VEC_BLK[2];
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(digest == VEC_DIG[1], "R8 first of back-to-back", digest, VEC_DIG[1]);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R8 restart on done cycle", 128'(busy), 128'd1);
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(digest == VEC_DIG[2], "R8 second of back-to-back", digest, VEC_DIG[2]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule